// File: doc/BRIEF.md
# SDRAM Byte-Masked Data Path

This block sits between a memory controller and the 16-bit bidirectional data bus of a synchronous DRAM. On the write side it registers each data beat together with its two byte masks and the pad output-enable, so all three reach the pins in the same clock. On the read side it captures the returning burst a fixed CAS latency after the READ command and labels each beat with its position in the burst. It also models the rule that a read-side mask changes the pins two clocks after the memory samples it. From that it builds per-byte valid flags and zeroes the bytes the memory left floating.

The controller raises `rd_start_i` in the cycle the READ command is on the command pins, so the memory samples it at the following edge. It supplies the read masks early enough to meet the two-clock rule. Write beats arriving while a read is in flight are dropped, so the pad never drives against returning data.

Top module: `sdq_datapath`

## Requirements
- R1: While reset is high the outputs are: `dq_oe_o` low, `dqm_o` all ones, `rd_valid_o` low and `rd_bvalid_o` all zero.
- R2: One cycle after `wr_beat_i` is accepted, `dq_oe_o` is high and `dq_out_o` equals the beat's data in that same cycle. `dqm_o` also equals the beat's `wr_mask_i`. Bit 0 of a mask covers the low byte (DQ7:DQ0) and bit 1 the high byte (DQ15:DQ8).
- R3: A write byte whose mask bit is 1 leaves the memory's old contents of that byte unchanged, and a byte whose mask bit is 0 is stored.
- R4: `dq_oe_o` is high only in the cycle after an accepted write beat.
- R5: If `rd_start_i` is sampled at edge E, data is captured at edges E+CAS_LAT+j for j = 0 to BURST_LEN-1. `rd_valid_o` is high in the cycle after each such edge, and `rd_beat_o` equals j in that cycle. `rd_last_o` is high only for j = BURST_LEN-1.
- R6: A mask level that the memory samples on `dqm_o` at edge X governs the same byte of the data captured at edge X+2.
- R7: During a valid beat, a byte whose governing mask bit was 1 gives `rd_bvalid_o` bit 0 and data 0x00, whatever the bus shows. An unmasked byte gives bit 1 and the bus byte. Outside valid beats `rd_bvalid_o` is zero.
- R8: From the cycle `rd_start_i` is high through the last capture edge, write beats are dropped. `dq_oe_o` therefore stays low during every data cycle and the cycle before it (CAS_LAT >= 2), and nothing is written.
- R9: In a cycle with no accepted write beat, `dqm_o` takes the `rd_mask_i` value of the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_beat_i | input | 1 | Write beat present this cycle |
| wr_data_i | input | DATA_W | Write beat data |
| wr_mask_i | input | DATA_W/8 | Write byte masks, 1 blocks the byte |
| rd_start_i | input | 1 | READ command is on the command pins this cycle |
| rd_mask_i | input | DATA_W/8 | Read-side byte masks to place on the pins |
| dq_i | input | DATA_W | Data bus as seen from the pad |
| dq_out_o | output | DATA_W | Data driven toward the pad |
| dq_oe_o | output | 1 | Pad output-enable |
| dqm_o | output | DATA_W/8 | Byte masks on the pins |
| rd_valid_o | output | 1 | Captured read beat valid |
| rd_data_o | output | DATA_W | Captured read data, masked bytes zero |
| rd_bvalid_o | output | DATA_W/8 | Per-byte valid of the captured beat |
| rd_beat_o | output | clog2(BURST_LEN) | Index of the beat within its burst |
| rd_last_o | output | 1 | Final beat of the burst |

## Verification
Every cycle, the assertions check that the write data, masks and output-enable line up. They check that the output-enable is never high in or just before a capture cycle. They also check that each byte valid flag matches the mask sampled three cycles earlier, that masked bytes read as zero, and that beat indices count up without gaps. Some behaviour only the bench scenarios can show, because it needs a memory model: masked write bytes keep old contents, and a write attempted during a read is really lost. The bench also checks that capture starts exactly CAS_LAT edges after the command, using bursts with mixed per-beat masks.

// File: rtl/sdq_pkg.sv
package sdq_pkg;
  localparam int unsigned LANE_W = 8;

  typedef enum logic [1:0] {
    RP_IDLE  = 2'd0,
    RP_WAIT  = 2'd1,
    RP_BURST = 2'd2
  } rd_phase_e;
endpackage

// File: rtl/sdq_wr_stage.sv
module sdq_wr_stage #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NB     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_beat_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [NB-1:0]     wr_mask_i,
  input  logic [NB-1:0]     rd_mask_i,
  input  logic              hold_off_i,
  output logic [DATA_W-1:0] dq_out_o,
  output logic              dq_oe_o,
  output logic [NB-1:0]     dqm_o
);
  logic wr_go;

  assign wr_go = wr_beat_i & ~hold_off_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_out_o <= '0;
      dq_oe_o  <= 1'b0;
      dqm_o    <= '1;
    end else begin
      dq_oe_o <= wr_go;
      dqm_o   <= wr_go ? wr_mask_i : rd_mask_i;
      if (wr_go) begin
        dq_out_o <= wr_data_i;
      end
    end
  end
endmodule

// File: rtl/sdq_rd_sched.sv
module sdq_rd_sched
  import sdq_pkg::*;
#(
  parameter int unsigned CAS_LAT   = 2,
  parameter int unsigned BURST_LEN = 4,
  parameter int unsigned BW        = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_start_i,
  output logic          cap_o,
  output logic [BW-1:0] cap_idx_o,
  output logic          cap_last_o,
  output logic          busy_o
);
  localparam int unsigned CW = $clog2(CAS_LAT + 1);
  localparam logic [CW-1:0] LAT_END  = CW'(CAS_LAT);
  localparam logic [BW-1:0] BEAT_END = BW'(BURST_LEN - 1);

  rd_phase_e     phase;
  logic [CW-1:0] lat_cnt;
  logic [BW-1:0] idx;

  always_comb begin
    cap_o      = (phase == RP_BURST) || ((phase == RP_WAIT) && (lat_cnt == LAT_END));
    cap_idx_o  = (phase == RP_BURST) ? idx : '0;
    cap_last_o = cap_o && (cap_idx_o == BEAT_END);
    busy_o     = rd_start_i || (phase != RP_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= RP_IDLE;
      lat_cnt <= '0;
      idx     <= '0;
    end else if (rd_start_i) begin
      phase   <= RP_WAIT;
      lat_cnt <= CW'(1);
      idx     <= '0;
    end else begin
      case (phase)
        RP_WAIT: begin
          if (lat_cnt == LAT_END) begin
            phase <= (BURST_LEN > 1) ? RP_BURST : RP_IDLE;
            idx   <= BW'(1);
          end else begin
            lat_cnt <= lat_cnt + CW'(1);
          end
        end
        RP_BURST: begin
          if (idx == BEAT_END) begin
            phase <= RP_IDLE;
          end else begin
            idx <= idx + BW'(1);
          end
        end
        default: phase <= RP_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdq_rd_mask_pipe.sv
module sdq_rd_mask_pipe #(
  parameter int unsigned NB = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NB-1:0] pin_mask_i,
  output logic [NB-1:0] lane_off_o
);
  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic seen_q;
    logic due_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        seen_q <= 1'b1;
        due_q  <= 1'b1;
      end else begin
        seen_q <= pin_mask_i[g];
        due_q  <= seen_q;
      end
    end

    assign lane_off_o[g] = due_q;
  end
endmodule

// File: rtl/sdq_rd_capture.sv
module sdq_rd_capture
  import sdq_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NB     = 2,
  parameter int unsigned BW     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_i,
  input  logic [BW-1:0]     cap_idx_i,
  input  logic              cap_last_i,
  input  logic [NB-1:0]     lane_off_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [NB-1:0]     rd_bvalid_o,
  output logic [BW-1:0]     rd_beat_o,
  output logic              rd_last_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_o <= 1'b0;
      rd_beat_o  <= '0;
      rd_last_o  <= 1'b0;
    end else begin
      rd_valid_o <= cap_i;
      rd_last_o  <= cap_last_i;
      if (cap_i) begin
        rd_beat_o <= cap_idx_i;
      end
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic              ok_q;
    logic [LANE_W-1:0] byte_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        ok_q   <= 1'b0;
        byte_q <= '0;
      end else if (cap_i) begin
        ok_q   <= ~lane_off_i[g];
        byte_q <= lane_off_i[g] ? '0 : dq_i[g*LANE_W +: LANE_W];
      end else begin
        ok_q <= 1'b0;
      end
    end

    assign rd_bvalid_o[g]                 = ok_q;
    assign rd_data_o[g*LANE_W +: LANE_W] = byte_q;
  end
endmodule

// File: rtl/sdq_datapath.sv
module sdq_datapath
  import sdq_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned CAS_LAT   = 2,
  parameter int unsigned BURST_LEN = 4,
  localparam int unsigned NB       = DATA_W / LANE_W,
  localparam int unsigned BW       = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_beat_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [NB-1:0]     wr_mask_i,
  input  logic              rd_start_i,
  input  logic [NB-1:0]     rd_mask_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_out_o,
  output logic              dq_oe_o,
  output logic [NB-1:0]     dqm_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [NB-1:0]     rd_bvalid_o,
  output logic [BW-1:0]     rd_beat_o,
  output logic              rd_last_o
);
  logic          busy;
  logic          cap;
  logic [BW-1:0] cap_idx;
  logic          cap_last;
  logic [NB-1:0] lane_off;

  sdq_wr_stage #(.DATA_W(DATA_W), .NB(NB)) u_wr (
    .clk        (clk),
    .rst        (rst),
    .wr_beat_i  (wr_beat_i),
    .wr_data_i  (wr_data_i),
    .wr_mask_i  (wr_mask_i),
    .rd_mask_i  (rd_mask_i),
    .hold_off_i (busy),
    .dq_out_o   (dq_out_o),
    .dq_oe_o    (dq_oe_o),
    .dqm_o      (dqm_o)
  );

  sdq_rd_sched #(.CAS_LAT(CAS_LAT), .BURST_LEN(BURST_LEN), .BW(BW)) u_sched (
    .clk        (clk),
    .rst        (rst),
    .rd_start_i (rd_start_i),
    .cap_o      (cap),
    .cap_idx_o  (cap_idx),
    .cap_last_o (cap_last),
    .busy_o     (busy)
  );

  sdq_rd_mask_pipe #(.NB(NB)) u_mpipe (
    .clk        (clk),
    .rst        (rst),
    .pin_mask_i (dqm_o),
    .lane_off_o (lane_off)
  );

  sdq_rd_capture #(.DATA_W(DATA_W), .NB(NB), .BW(BW)) u_cap (
    .clk         (clk),
    .rst         (rst),
    .cap_i       (cap),
    .cap_idx_i   (cap_idx),
    .cap_last_i  (cap_last),
    .lane_off_i  (lane_off),
    .dq_i        (dq_i),
    .rd_valid_o  (rd_valid_o),
    .rd_data_o   (rd_data_o),
    .rd_bvalid_o (rd_bvalid_o),
    .rd_beat_o   (rd_beat_o),
    .rd_last_o   (rd_last_o)
  );
endmodule

// File: rtl/sdq_datapath_chk.sv
module sdq_datapath_chk #(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned BURST_LEN = 4,
  parameter int unsigned NB        = 2,
  parameter int unsigned BW        = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_beat_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [NB-1:0]     wr_mask_i,
  input logic [NB-1:0]     rd_mask_i,
  input logic [DATA_W-1:0] dq_out_o,
  input logic              dq_oe_o,
  input logic [NB-1:0]     dqm_o,
  input logic              rd_valid_o,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [NB-1:0]     rd_bvalid_o,
  input logic [BW-1:0]     rd_beat_o,
  input logic              rd_last_o
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  AST_WR_ALIGN: assert property (@(posedge clk) disable iff (rst)
    dq_oe_o |-> (dq_out_o == $past(wr_data_i)) && (dqm_o == $past(wr_mask_i))); // R2

  AST_OE_ONLY_WRITE: assert property (@(posedge clk) disable iff (rst)
    dq_oe_o |-> $past(wr_beat_i)); // R4

  AST_BEAT_ORDER: assert property (@(posedge clk) disable iff (rst)
    (rd_valid_o && rd_beat_o != '0) |-> ($past(rd_valid_o) && rd_beat_o == $past(rd_beat_o) + BW'(1))); // R5

  AST_LAST_TAG: assert property (@(posedge clk) disable iff (rst)
    rd_last_o |-> (rd_valid_o && rd_beat_o == BW'(BURST_LEN - 1))); // R5

  AST_MASK_TWO_CLK: assert property (@(posedge clk) disable iff (rst)
    rd_valid_o |-> ((rd_bvalid_o ^ $past(dqm_o, 3)) == '1)); // R6

  AST_IDLE_NO_BVALID: assert property (@(posedge clk) disable iff (rst)
    !rd_valid_o |-> (rd_bvalid_o == '0)); // R7

  for (genvar g = 0; g < NB; g++) begin : g_lane
    AST_MASKED_ZERO: assert property (@(posedge clk) disable iff (rst)
      (rd_valid_o && !rd_bvalid_o[g]) |-> (rd_data_o[g*8 +: 8] == 8'h00)); // R7
  end

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
    rd_valid_o |-> (!$past(dq_oe_o) && !$past(dq_oe_o, 2))); // R8

  AST_DQM_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (armed && !dq_oe_o) |-> (dqm_o == $past(rd_mask_i))); // R9
endmodule

bind sdq_datapath sdq_datapath_chk #(
  .DATA_W(DATA_W), .BURST_LEN(BURST_LEN), .NB(NB), .BW(BW)
) u_chk (
  .clk(clk), .rst(rst), .wr_beat_i(wr_beat_i), .wr_data_i(wr_data_i),
  .wr_mask_i(wr_mask_i), .rd_mask_i(rd_mask_i), .dq_out_o(dq_out_o),
  .dq_oe_o(dq_oe_o), .dqm_o(dqm_o), .rd_valid_o(rd_valid_o),
  .rd_data_o(rd_data_o), .rd_bvalid_o(rd_bvalid_o), .rd_beat_o(rd_beat_o),
  .rd_last_o(rd_last_o)
);

// File: tb/sdq_datapath_tb.sv
module sdq_datapath_tb;
  localparam int CAS = 2;
  localparam int BL  = 4;
  localparam int C0  = (CAS < 3) ? CAS - 3 : 0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_beat_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic [1:0]  wr_mask_i = '1;
  logic        rd_start_i = 1'b0;
  logic [1:0]  rd_mask_i = '1;
  logic [15:0] dq_i;
  logic [15:0] dq_out_o;
  logic        dq_oe_o;
  logic [1:0]  dqm_o;
  logic        rd_valid_o;
  logic [15:0] rd_data_o;
  logic [1:0]  rd_bvalid_o;
  logic [1:0]  rd_beat_o;
  logic        rd_last_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sdq_datapath #(.DATA_W(16), .CAS_LAT(CAS), .BURST_LEN(BL)) u_dut (
    .clk(clk), .rst(rst), .wr_beat_i(wr_beat_i), .wr_data_i(wr_data_i),
    .wr_mask_i(wr_mask_i), .rd_start_i(rd_start_i), .rd_mask_i(rd_mask_i),
    .dq_i(dq_i), .dq_out_o(dq_out_o), .dq_oe_o(dq_oe_o), .dqm_o(dqm_o),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .rd_bvalid_o(rd_bvalid_o),
    .rd_beat_o(rd_beat_o), .rd_last_o(rd_last_o)
  );

  // Behavioural byte-masked memory on the pin side.
  logic [15:0] mem_m [64];
  logic [15:0] exp_mem [64];
  int   ph = 0;
  int   rb_m = 0, rb_in = 0;
  int   wa_pin = 0, wa_in = 0;
  logic [1:0] m1 = '1, m2 = '1;

  always @(posedge clk) begin
    m1 <= dqm_o;
    m2 <= m1;
    wa_pin <= wa_in;
    if (rd_start_i) begin
      ph   <= 1;
      rb_m <= rb_in;
    end else if (ph != 0 && ph < 1000) begin
      ph <= ph + 1;
    end
    if (!rst && dq_oe_o) begin
      for (int b = 0; b < 2; b++)
        if (!dqm_o[b]) mem_m[wa_pin & 63][b*8 +: 8] <= dq_out_o[b*8 +: 8];
    end
  end

  always @* begin
    dq_i = 16'hDEAD;
    if (ph >= CAS && ph < CAS + BL) begin
      for (int b = 0; b < 2; b++)
        dq_i[b*8 +: 8] = m2[b] ? 8'hA5 : mem_m[(rb_m + ph - CAS) & 63][b*8 +: 8];
    end
  end

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw,
                                        input logic [1:0] m);
    logic [15:0] r = old;
    for (int b = 0; b < 2; b++) if (!m[b]) r[b*8 +: 8] = nw[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [15:0] masked_view(input logic [15:0] v, input logic [1:0] m);
    logic [15:0] r = v;
    for (int b = 0; b < 2; b++) if (m[b]) r[b*8 +: 8] = 8'h00;
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input int base, input logic [16*BL-1:0] dat, input logic [2*BL-1:0] msk);
    for (int i = 0; i <= BL; i++) begin
      @(negedge clk);
      if (i > 0) begin
        check(dq_oe_o == 1'b1, "R2", "oe on write beat", {31'd0, dq_oe_o}, 32'd1);
        check(dq_out_o == dat[16*(i-1) +: 16], "R2", "dq_out", {16'd0, dq_out_o}, {16'd0, dat[16*(i-1) +: 16]});
        check(dqm_o == msk[2*(i-1) +: 2], "R2", "dqm on write", {30'd0, dqm_o}, {30'd0, msk[2*(i-1) +: 2]});
      end
      if (i < BL) begin
        wr_beat_i = 1'b1;
        wr_data_i = dat[16*i +: 16];
        wr_mask_i = msk[2*i +: 2];
        wa_in     = base + i;
        exp_mem[base + i] = merge(exp_mem[base + i], dat[16*i +: 16], msk[2*i +: 2]);
      end else begin
        wr_beat_i = 1'b0;
        wr_mask_i = '1;
      end
    end
    @(negedge clk);
    check(dq_oe_o == 1'b0, "R4", "oe after write", {31'd0, dq_oe_o}, 32'd0);
  endtask

  task automatic do_read(input int base, input logic [2*BL-1:0] msk, input bit noise);
    logic [1:0] prev_m = rd_mask_i;
    rb_in = base;
    for (int c = C0; c <= CAS + BL + 1; c++) begin
      int j;
      int k;
      @(negedge clk);
      j = c - CAS - 1;
      if (j >= 0 && j < BL) begin
        logic [1:0]  em = msk[2*j +: 2];
        logic [15:0] ed = masked_view(exp_mem[base + j], em);
        check(rd_valid_o == 1'b1, "R5", "valid in beat", {31'd0, rd_valid_o}, 32'd1);
        check(rd_beat_o == 2'(j), "R5", "beat index", {30'd0, rd_beat_o}, j);
        check(rd_last_o == (j == BL - 1), "R5", "last flag", {31'd0, rd_last_o}, {31'd0, j == BL - 1});
        check(rd_bvalid_o == ~em, "R6", "byte valid vs mask", {30'd0, rd_bvalid_o}, {30'd0, ~em});
        check(rd_data_o == ed, "R7", "read data (R3 stored bytes)", {16'd0, rd_data_o}, {16'd0, ed});
      end else begin
        check(rd_valid_o == 1'b0, "R5", "no valid outside burst", {31'd0, rd_valid_o}, 32'd0);
        check(rd_bvalid_o == 2'b00, "R7", "no byte valid outside burst", {30'd0, rd_bvalid_o}, 32'd0);
      end
      if (c > C0 && !dq_oe_o)
        check(dqm_o == prev_m, "R9", "dqm follows rd_mask", {30'd0, dqm_o}, {30'd0, prev_m});
      if (c >= 1 && c <= CAS + BL)
        check(dq_oe_o == 1'b0, "R8", "oe low during read", {31'd0, dq_oe_o}, 32'd0);
      rd_start_i = (c == 0);
      k = c - CAS + 3;
      rd_mask_i = (k >= 0 && k < BL) ? msk[2*k +: 2] : 2'b11;
      prev_m = rd_mask_i;
      wr_beat_i = noise && (c >= 0 && c <= CAS + BL - 1);
      wr_data_i = 16'(($urandom));
      wr_mask_i = 2'b00;
      wa_in = base;
    end
    rd_start_i = 1'b0;
    wr_beat_i  = 1'b0;
    rd_mask_i  = 2'b11;
    wr_mask_i  = 2'b11;
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 64; i++) begin
      mem_m[i]   = 16'(i * 16'h0101) ^ 16'h3C5A;
      exp_mem[i] = 16'(i * 16'h0101) ^ 16'h3C5A;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(dq_oe_o == 1'b0, "R1", "reset oe", {31'd0, dq_oe_o}, 32'd0);
    check(dqm_o == 2'b11, "R1", "reset dqm", {30'd0, dqm_o}, 32'd3);
    check(rd_valid_o == 1'b0, "R1", "reset valid", {31'd0, rd_valid_o}, 32'd0);
    check(rd_bvalid_o == 2'b00, "R1", "reset bvalid", {30'd0, rd_bvalid_o}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    // Directed: one burst with every mask combination, then read back unmasked (R3).
    do_write(8, {16'h7788, 16'h5566, 16'h3344, 16'h1122}, {2'b11, 2'b10, 2'b01, 2'b00});
    do_read(8, 8'h00, 1'b0);
    // Directed: all lanes masked on read, then low lane only masked.
    do_read(8, 8'hFF, 1'b0);
    do_read(20, {2'b01, 2'b01, 2'b01, 2'b01}, 1'b0);
    // Directed: write attempts during a read are dropped (R8), confirmed by a clean re-read.
    do_read(8, 8'h00, 1'b1);
    do_read(8, 8'h00, 1'b0);

    for (int it = 0; it < 80; it++) begin
      int base = $urandom_range(0, 63 - BL);
      if ($urandom_range(0, 1) == 0) begin
        logic [16*BL-1:0] d;
        for (int b = 0; b < BL; b++) d[16*b +: 16] = 16'($urandom);
        do_write(base, d, 8'($urandom));
      end else begin
        do_read(base, 8'($urandom), ($urandom_range(0, 3) == 0));
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R5 watchdog expired: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule